// File: doc/BRIEF.md
# Serial Byte Echo with Early Stop-Bit Release

This block receives asynchronous serial bytes on one wire and sends each one straight back on another wire. Both directions use 8N1 frames: a low start bit, eight data bits with the least significant bit first, and a high stop bit. A single divider makes a tick at sixteen times the bit rate, and both the receiver and the transmitter run on it. Each bit lasts 16 ticks, and each tick lasts `CLK_DIV` system clocks. The default divider gives roughly 9600 bit/s from a 250 MHz clock.

A remote sender whose clock runs slightly fast delivers bytes faster than a transmitter that always sends full frames can drain them. Two rules keep the echo path from falling behind:
- The receiver reports each byte at the middle of its stop bit and is armed for the next start edge from that moment.
- Once eight ticks of a stop bit have gone out and another byte is waiting, the transmitter ends the stop bit and starts the next frame at once.

Inside the block the receiver offers each finished byte as a one-cycle valid pulse. The transmitter's one-byte holding register takes the byte when its ready is high. Ready is high when the register is empty, or when it is being emptied into the shifter in that same cycle. A byte offered while ready is low is lost and sets a sticky overrun flag.

Top module: `uart_echo`

## Requirements
- R1: After reset, `tx_o` is high and `frame_err_o` and `overrun_o` are low.
- R2: Every byte received with a good stop bit is sent back on `tx_o` as one start bit (0), eight data bits least significant bit first, and a stop bit (1). Each bit is 16 ticks of `CLK_DIV` clocks.
- R3: The receiver synchronises `rx_i` through two flops, starts on a high-to-low edge and samples each bit at its centre. Frames arriving back to back from a sender whose bit period is about 1.6% short are all echoed, in order.
- R4: The receiver treats a byte as complete at the middle of its stop bit and is armed for a new start edge from then on. Frames whose stop bit lasts only 0.6 of a bit are all received and echoed.
- R5: A stop bit sent on `tx_o` is never shorter than 8 ticks. It is cut to between 8 and 16 ticks only when the next byte is already waiting.
- R6: If the start bit is high again at its mid-point sample, the receiver drops it, produces no byte, and raises no error.
- R7: A frame whose stop bit samples low gives a one-cycle pulse on `frame_err_o`, and its byte is not echoed.
- R8: `overrun_o` is set when a byte completes while the transmit holding register is full and cannot be emptied that cycle. It then stays set until reset. It stays low under all the traffic of R2 to R4.
- R9: The receive-to-transmit hand-off is valid/ready: the valid pulse lasts one cycle, and an accepted byte fills the holding register in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_i | input | 1 | Serial input, idles high |
| tx_o | output | 1 | Serial echo output, idles high |
| frame_err_o | output | 1 | One-cycle pulse when a received stop bit is low |
| overrun_o | output | 1 | Sticky flag: a received byte was dropped |

## Verification
A wrong bit counter or sampling phase in the receiver appears on `tx_o` about one frame later, as an echoed byte with the wrong value. A stuck phase state appears as an echo that never arrives. If the stop-bit release is broken, the damage builds slowly: back-to-back traffic from a fast sender shows dropped bytes and a raised `overrun_o` only after tens of frames. For that reason the bursts are long. Glitch and framing faults show within one frame, either as a spurious echo or as a missing or extra `frame_err_o` pulse.

// File: rtl/uart_echo_pkg.sv
package uart_echo_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_START, PH_DATA, PH_STOP} phase_e;
  localparam int TICKS_PER_BIT = 16;
  localparam int HALF_TICKS    = TICKS_PER_BIT / 2;
  localparam int DATA_BITS     = 8;
  localparam int TCW           = $clog2(TICKS_PER_BIT);
  localparam int BCW           = $clog2(DATA_BITS);
endpackage

// File: rtl/baud_tick.sv
module baud_tick #(
  parameter int CLK_DIV = 1628
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == CW'(CLK_DIV - 1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  generate
    if (CLK_DIV > 1) begin : g_spacing
      // R2
      tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_echo_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 rx_i,
  output logic                 out_vld,
  output logic [DATA_BITS-1:0] out_data,
  output logic                 frame_err
);
  logic s1, s2, s3;
  phase_e ph;
  logic [TCW-1:0] tcnt;
  logic [BCW-1:0] bcnt;
  logic [DATA_BITS-1:0] sh;
  logic fall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b1; s2 <= 1'b1; s3 <= 1'b1;
    end else begin
      s1 <= rx_i; s2 <= s1; s3 <= s2;
    end
  end

  assign fall = s3 & ~s2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph        <= PH_IDLE;
      tcnt      <= '0;
      bcnt      <= '0;
      sh        <= '0;
      out_vld   <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      out_vld   <= 1'b0;
      frame_err <= 1'b0;
      case (ph)
        PH_IDLE: if (fall) begin
          ph   <= PH_START;
          tcnt <= '0;
        end
        PH_START: if (tick) begin
          if (tcnt == TCW'(HALF_TICKS - 1)) begin
            tcnt <= '0;
            bcnt <= '0;
            ph   <= s2 ? PH_IDLE : PH_DATA;
          end else tcnt <= tcnt + 1'b1;
        end
        PH_DATA: if (tick) begin
          if (tcnt == TCW'(TICKS_PER_BIT - 1)) begin
            sh   <= {s2, sh[DATA_BITS-1:1]};
            tcnt <= '0;
            if (bcnt == BCW'(DATA_BITS - 1)) ph <= PH_STOP;
            else bcnt <= bcnt + 1'b1;
          end else tcnt <= tcnt + 1'b1;
        end
        default: if (tick) begin
          if (tcnt == TCW'(TICKS_PER_BIT - 1)) begin
            tcnt <= '0;
            ph   <= PH_IDLE;
            if (s2) out_vld <= 1'b1;
            else    frame_err <= 1'b1;
          end else tcnt <= tcnt + 1'b1;
        end
      endcase
    end
  end

  assign out_data = sh;

  // R9
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |=> !out_vld);
  // R4
  rx_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> ph == PH_IDLE);
  // R7
  rx_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> !out_vld);
endmodule

// File: rtl/uart_tx_frame.sv
module uart_tx_frame
  import uart_echo_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 in_vld,
  input  logic [DATA_BITS-1:0] in_data,
  output logic                 in_rdy,
  output logic                 tx_o
);
  phase_e ph;
  logic [TCW-1:0] tcnt;
  logic [BCW-1:0] bcnt;
  logic [DATA_BITS-1:0] sh;
  logic pend_vld;
  logic [DATA_BITS-1:0] pend_data;
  logic launch;

  assign launch = tick && pend_vld &&
                  ((ph == PH_IDLE) ||
                   (ph == PH_STOP && tcnt >= TCW'(HALF_TICKS - 1)));
  assign in_rdy = !pend_vld || launch;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_vld  <= 1'b0;
      pend_data <= '0;
    end else begin
      if (launch) pend_vld <= 1'b0;
      if (in_vld && in_rdy) begin
        pend_vld  <= 1'b1;
        pend_data <= in_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph   <= PH_IDLE;
      tcnt <= '0;
      bcnt <= '0;
      sh   <= '0;
    end else if (launch) begin
      ph   <= PH_START;
      tcnt <= '0;
      sh   <= pend_data;
    end else if (tick) begin
      case (ph)
        PH_START: begin
          if (tcnt == TCW'(TICKS_PER_BIT - 1)) begin
            ph   <= PH_DATA;
            tcnt <= '0;
            bcnt <= '0;
          end else tcnt <= tcnt + 1'b1;
        end
        PH_DATA: begin
          if (tcnt == TCW'(TICKS_PER_BIT - 1)) begin
            sh   <= sh >> 1;
            tcnt <= '0;
            if (bcnt == BCW'(DATA_BITS - 1)) ph <= PH_STOP;
            else bcnt <= bcnt + 1'b1;
          end else tcnt <= tcnt + 1'b1;
        end
        PH_STOP: begin
          if (tcnt == TCW'(TICKS_PER_BIT - 1)) begin
            ph   <= PH_IDLE;
            tcnt <= '0;
          end else tcnt <= tcnt + 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (ph)
      PH_START: tx_o = 1'b0;
      PH_DATA:  tx_o = sh[0];
      default:  tx_o = 1'b1;
    endcase
  end

  // checker state: ticks seen while the line is high, saturating
  logic [4:0] hi_ticks;
  always_ff @(posedge clk) begin
    if (!rst_n) hi_ticks <= 5'd16;
    else if (!tx_o) hi_ticks <= '0;
    else if (tick && hi_ticks != 5'd31) hi_ticks <= hi_ticks + 1'b1;
  end

  // R5
  stop_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_o) |-> hi_ticks >= 5'(HALF_TICKS));
  // R9
  hold_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_rdy) |=> pend_vld);
endmodule

// File: rtl/uart_echo.sv
module uart_echo
  import uart_echo_pkg::*;
#(
  parameter int CLK_DIV = 1628
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_i,
  output logic tx_o,
  output logic frame_err_o,
  output logic overrun_o
);
  logic tick;
  logic rx_vld, tx_rdy;
  logic [DATA_BITS-1:0] rx_data;

  baud_tick #(.CLK_DIV(CLK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  uart_rx_frame u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx_i(rx_i),
    .out_vld(rx_vld), .out_data(rx_data), .frame_err(frame_err_o)
  );

  uart_tx_frame u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .in_vld(rx_vld), .in_data(rx_data), .in_rdy(tx_rdy), .tx_o(tx_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) overrun_o <= 1'b0;
    else if (rx_vld && !tx_rdy) overrun_o <= 1'b1;
  end

  // R8
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |=> overrun_o);
  // R8
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_vld && !tx_rdy) |=> overrun_o);
endmodule

// File: tb/sim_uart_echo.sv
module sim_uart_echo;
  localparam int DIV = 4;
  localparam int BITC = 16 * DIV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx = 1'b1;
  logic tx_o, frame_err_o, overrun_o;

  int total = 0;
  int bad = 0;
  int fe_cnt = 0;
  bit finished = 1'b0;
  string cur_req = "R2";
  logic [7:0] exp_q[$];

  always #2 clk = ~clk;

  uart_echo #(.CLK_DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .tx_o(tx_o),
    .frame_err_o(frame_err_o), .overrun_o(overrun_o)
  );

  always @(negedge clk) if (rst_n && frame_err_o) fe_cnt++;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // driver: one frame on rx; a good frame is pushed to the scoreboard
  task automatic send(input logic [7:0] b, input int bitc, input int stopc, input bit good);
    if (good) exp_q.push_back(b);
    rx = 1'b0;
    repeat (bitc) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx = b[i];
      repeat (bitc) @(negedge clk);
    end
    if (!good) begin
      rx = 1'b0;
      repeat (bitc) @(negedge clk);
    end
    rx = 1'b1;
    repeat (stopc) @(negedge clk);
  endtask

  // monitor: decodes tx_o at nominal rate and compares with the scoreboard
  initial begin
    logic [7:0] got;
    forever begin
      @(negedge clk);
      if (rst_n && tx_o == 1'b0) begin
        repeat (BITC / 2) @(negedge clk);
        check({cur_req, " start bit"}, int'(tx_o), 0);
        for (int i = 0; i < 8; i++) begin
          repeat (BITC) @(negedge clk);
          got[i] = tx_o;
        end
        repeat (BITC / 2 + BITC / 4) @(negedge clk);
        check({cur_req, " stop bit"}, int'(tx_o), 1);
        if (exp_q.size() == 0) begin
          total++; bad++;
          $display("FAIL %s: actual=%0h expected=none (unexpected echo)", cur_req, got);
        end else begin
          check({cur_req, " echo data"}, int'(got), int'(exp_q.pop_front()));
        end
        while (tx_o == 1'b0) @(negedge clk);
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=done");
    finish_run();
  end

  initial begin
    int fe0;
    repeat (5) @(negedge clk);
    // R1 reset state
    check("R1 tx idle", int'(tx_o), 1);
    check("R1 frame_err", int'(frame_err_o), 0);
    check("R1 overrun", int'(overrun_o), 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);

    // R2 nominal echo, varied patterns
    cur_req = "R2";
    send(8'h55, BITC, BITC, 1'b1);
    send(8'hA3, BITC, BITC, 1'b1);
    send(8'h00, BITC, BITC, 1'b1);
    send(8'hFF, BITC, BITC, 1'b1);
    send(8'h01, BITC, 3 * BITC, 1'b1);
    repeat (1500) @(negedge clk);
    check("R2 all echoed", exp_q.size(), 0);

    // R3 R5 R9: long back-to-back burst from a sender about 1.6% fast
    cur_req = "R3/R5";
    for (int k = 0; k < 80; k++) send(8'(k * 37 + 11), BITC - 1, BITC - 1, 1'b1);
    repeat (1500) @(negedge clk);
    check("R3 burst all echoed", exp_q.size(), 0);
    check("R5 no overrun after fast burst", int'(overrun_o), 0);

    // R4: stop bit only 0.6 of a bit long
    cur_req = "R4";
    for (int k = 0; k < 12; k++) send(8'(k * 91 + 5), BITC, (BITC * 6) / 10, 1'b1);
    repeat (1500) @(negedge clk);
    check("R4 short stop all echoed", exp_q.size(), 0);

    // R6 glitch on the line: no echo, no error, then a good byte still works
    cur_req = "R6";
    fe0 = fe_cnt;
    rx = 1'b0;
    repeat (2 * DIV) @(negedge clk);
    rx = 1'b1;
    repeat (1500) @(negedge clk);
    check("R6 glitch no error", fe_cnt, fe0);
    check("R6 glitch line idle", int'(tx_o), 1);
    send(8'h3C, BITC, BITC, 1'b1);
    repeat (1500) @(negedge clk);
    check("R6 byte after glitch", exp_q.size(), 0);

    // R7 bad stop bit: one pulse, nothing echoed
    cur_req = "R7";
    fe0 = fe_cnt;
    send(8'h96, BITC, BITC, 1'b0);
    repeat (1500) @(negedge clk);
    check("R7 one frame error pulse", fe_cnt, fe0 + 1);
    check("R7 no echo", exp_q.size(), 0);
    send(8'hC7, BITC, BITC, 1'b1);
    repeat (1500) @(negedge clk);
    check("R7 recovery echo", exp_q.size(), 0);

    // R8 R9: overrun never raised by legal traffic
    check("R8 overrun clear", int'(overrun_o), 0);
    check("R9 hand-off lost nothing", exp_q.size(), 0);
    finish_run();
  end
endmodule